// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block walks a freshly reset DRAM device through its power-up command list, with no software involved. At the first clock edge after reset it samples a strap that picks the DDR1 or the DDR2 flavour. It then steps through that flavour's list. Each step raises one command strobe for a single cycle and presents a mode-register value alongside it. After each step the block waits a settle gap before it issues the next one.

In DDR2 mode the list first touches the second and third extended mode registers and pulses a pad-configuration strobe, all with short gaps. It also finishes with an on-chip-driver calibration enter/exit pair on the extended mode register. When the final gap has elapsed, the block raises a done flag and publishes two results: the refresh control word and the per-lane DQS delay tap values for the chosen flavour. It then stays silent until the next reset.

The gaps are counted in clock cycles. Their lengths are derived from a clock-frequency parameter and microsecond parameters, and a divider parameter lets a test shrink them.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is held, every command strobe, the pad strobe, the argument bus, the done flag, the refresh word and all tap outputs read zero.
- R2: The strap value is latched on the first rising edge after reset release. Strap changes after that edge have no effect on the sequence.
- R3: Command strobe bits are one-hot: bit0 mode register, bit1 extended mode register, bit2 auto-refresh, bit3 precharge-all, bit4 second extended register, bit5 third extended register. At most one of these bits and the pad strobe is high in any cycle. Each strobe lasts exactly one cycle. The argument bus is zero whenever no command strobe is high.
- R4: The DDR1 list, with arguments, is: precharge-all; extended-mode 0x000; mode 0x133; precharge-all; auto-refresh; auto-refresh; mode 0x033.
- R5: The DDR2 list, with arguments, is: EMR2; EMR3; pad strobe; precharge-all; EMR2; EMR3; extended-mode 0x402; mode 0x143; precharge-all; auto-refresh; auto-refresh; mode 0x043; extended-mode 0x782; extended-mode 0x402. Non-mode steps carry argument 0.
- R6: The first strobe comes on the second rising edge after reset release. Each following strobe comes LONG cycles after the previous one, except that the three leading DDR2 steps are followed by SHORT cycles. LONG is LONG_US·CLK_MHZ/TIME_DIV and SHORT is SHORT_US·CLK_MHZ/TIME_DIV.
- R7: The done flag rises one gap after the last strobe and stays high until reset. No strobe is issued once it is high.
- R8: Before done, the refresh word and the taps read zero. From done onward, refresh_ctl holds enable at bit 14 and the count 312 in bits 9:0, which gives 0x4138. Every lane's tap reads 0x20 for DDR1 or 0x10 for DDR2.
- R9: A reset applied mid-sequence aborts it. After release the sequence restarts from its first step, using the newly latched strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ddr2 | input | 1 | Flavour strap, 1 selects DDR2 |
| cmd_stb | output | 6 | One-hot command strobe |
| cmd_arg | output | ARG_W | Mode or extended-mode value, valid with cmd_stb |
| pad_cfg_stb | output | 1 | One-cycle DDR2 pad configuration strobe |
| init_done | output | 1 | Sequence complete, sticky until reset |
| refresh_ctl | output | 16 | Refresh enable (bit 14) and interval count (bits 9:0) |
| dqs_tap | output | LANES*TAP_W | DQS delay tap per byte lane, lane 0 in the low bits |

## Verification
Every result is registered. The first strobe is due two rising edges after reset release: one edge latches the strap and the next issues the command. Each later strobe is due exactly one gap after the one before, and done, the refresh word and the taps become valid one gap after the last strobe. The bench counts falling edges from the release, logs every strobe with its time stamp, and compares each log entry against a time it works out by summing the expected gaps from its own step tables. Stimulus mixes directed runs with seeded random runs that vary strap, reset length, strap toggling after the latch edge, and mid-sequence resets.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   localparam int CMD_W       = 6;
   localparam int DDR1_STEPS  = 7;
   localparam int DDR2_STEPS  = 14;

   // Low six codes double as the strobe bit index
   typedef enum logic [2:0] {
      OP_MRS  = 3'd0,
      OP_EMR  = 3'd1,
      OP_REF  = 3'd2,
      OP_PRE  = 3'd3,
      OP_EMR2 = 3'd4,
      OP_EMR3 = 3'd5,
      OP_PAD  = 3'd6
   } seq_op_e;

   typedef struct packed {
      seq_op_e     op;
      logic [11:0] arg;
      logic        short_gap;
   } seq_step_t;

   typedef enum logic [1:0] {
      ST_LATCH,
      ST_ISSUE,
      ST_WAIT,
      ST_DONE
   } seq_state_e;

   function automatic seq_step_t mk(seq_op_e op, logic [11:0] arg, logic sg);
      seq_step_t s;
      s.op        = op;
      s.arg       = arg;
      s.short_gap = sg;
      return s;
   endfunction

   function automatic seq_step_t step_ddr1(int idx);
      case (idx)
         0:       return mk(OP_PRE, 12'h000, 1'b0);
         1:       return mk(OP_EMR, 12'h000, 1'b0);
         2:       return mk(OP_MRS, 12'h133, 1'b0);
         3:       return mk(OP_PRE, 12'h000, 1'b0);
         4:       return mk(OP_REF, 12'h000, 1'b0);
         5:       return mk(OP_REF, 12'h000, 1'b0);
         default: return mk(OP_MRS, 12'h033, 1'b0);
      endcase
   endfunction

   function automatic seq_step_t step_ddr2(int idx);
      case (idx)
         0:       return mk(OP_EMR2, 12'h000, 1'b1);
         1:       return mk(OP_EMR3, 12'h000, 1'b1);
         2:       return mk(OP_PAD,  12'h000, 1'b1);
         3:       return mk(OP_PRE,  12'h000, 1'b0);
         4:       return mk(OP_EMR2, 12'h000, 1'b0);
         5:       return mk(OP_EMR3, 12'h000, 1'b0);
         6:       return mk(OP_EMR,  12'h402, 1'b0);
         7:       return mk(OP_MRS,  12'h143, 1'b0);
         8:       return mk(OP_PRE,  12'h000, 1'b0);
         9:       return mk(OP_REF,  12'h000, 1'b0);
         10:      return mk(OP_REF,  12'h000, 1'b0);
         11:      return mk(OP_MRS,  12'h043, 1'b0);
         12:      return mk(OP_EMR,  12'h782, 1'b0);
         default: return mk(OP_EMR,  12'h402, 1'b0);
      endcase
   endfunction

endpackage

// File: rtl/seq_step_rom.sv
module seq_step_rom
   import dram_seq_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             ddr2,
   input  logic [IDX_W-1:0] idx,
   output seq_step_t        step,
   output logic             past_end
);

   initial begin
      if ((1 << IDX_W) <= DDR2_STEPS)
         $error("seq_step_rom: IDX_W too narrow for the step count");
   end

   always_comb begin
      if (ddr2) begin
         step     = step_ddr2(int'(idx));
         past_end = (idx >= IDX_W'(DDR2_STEPS));
      end else begin
         step     = step_ddr1(int'(idx));
         past_end = (idx >= IDX_W'(DDR1_STEPS));
      end
   end

endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R6
   gap_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt > CNT_W'(1)) |=> !expired);

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
   import dram_seq_pkg::*;
#(
   parameter int CLK_MHZ   = 200,
   parameter int LONG_US   = 100,
   parameter int SHORT_US  = 10,
   parameter int TIME_DIV  = 1,
   parameter int ARG_W     = 13,
   parameter int TAP_W     = 6,
   parameter int LANES     = 2,
   parameter int REF_COUNT = 312,
   parameter int DDR1_TAP  = 32,
   parameter int DDR2_TAP  = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   strap_ddr2,
   output logic [CMD_W-1:0]       cmd_stb,
   output logic [ARG_W-1:0]       cmd_arg,
   output logic                   pad_cfg_stb,
   output logic                   init_done,
   output logic [15:0]            refresh_ctl,
   output logic [LANES*TAP_W-1:0] dqs_tap
);

   localparam int LONG_CYC  = LONG_US * CLK_MHZ / TIME_DIV;
   localparam int SHORT_CYC = SHORT_US * CLK_MHZ / TIME_DIV;
   localparam int CNT_W     = $clog2(LONG_CYC + 1);
   localparam int IDX_W     = $clog2(DDR2_STEPS + 1);
   localparam logic [15:0] REFRESH_WORD = 16'h4000 | 16'(REF_COUNT);

   // Elaboration-time parameter checks
   initial begin
      if (SHORT_CYC < 2 || LONG_CYC < 2)
         $error("dram_init_seq: gaps must be at least two cycles");
      if (ARG_W < 12)
         $error("dram_init_seq: ARG_W must hold 12-bit mode values");
      if (REF_COUNT >= 1024)
         $error("dram_init_seq: refresh count exceeds its 10-bit field");
      if (DDR1_TAP >= (1 << TAP_W) || DDR2_TAP >= (1 << TAP_W))
         $error("dram_init_seq: tap value exceeds TAP_W");
      if (LANES < 1)
         $error("dram_init_seq: at least one lane required");
   end

   seq_state_e       st;
   logic             flav;
   logic [IDX_W-1:0] idx;
   seq_step_t        step;
   logic             past_end;
   logic             gap_load;
   logic [CNT_W-1:0] gap_val;
   logic             gap_expired;

   seq_step_rom #(.IDX_W(IDX_W)) u_rom (
      .ddr2     (flav),
      .idx      (idx),
      .step     (step),
      .past_end (past_end)
   );

   assign gap_load = (st == ST_ISSUE) && !past_end;
   assign gap_val  = step.short_gap ? CNT_W'(SHORT_CYC - 2) : CNT_W'(LONG_CYC - 2);

   seq_gap_timer #(.CNT_W(CNT_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (gap_val),
      .expired  (gap_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_LATCH;
         flav        <= 1'b0;
         idx         <= '0;
         cmd_stb     <= '0;
         cmd_arg     <= '0;
         pad_cfg_stb <= 1'b0;
         init_done   <= 1'b0;
      end else begin
         cmd_stb     <= '0;
         cmd_arg     <= '0;
         pad_cfg_stb <= 1'b0;
         case (st)
            ST_LATCH: begin
               flav <= strap_ddr2;
               st   <= ST_ISSUE;
            end
            ST_ISSUE: begin
               if (past_end) begin
                  init_done <= 1'b1;
                  st        <= ST_DONE;
               end else begin
                  if (step.op == OP_PAD)
                     pad_cfg_stb <= 1'b1;
                  else begin
                     cmd_stb <= CMD_W'(1) << step.op;
                     cmd_arg <= ARG_W'(step.arg);
                  end
                  st <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (gap_expired) begin
                  idx <= idx + 1'b1;
                  st  <= ST_ISSUE;
               end
            end
            default: st <= ST_DONE;
         endcase
      end
   end

   assign refresh_ctl = init_done ? REFRESH_WORD : 16'h0000;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign dqs_tap[l*TAP_W +: TAP_W] =
            !init_done ? '0 : (flav ? TAP_W'(DDR2_TAP) : TAP_W'(DDR1_TAP));
      end
   endgenerate

   // R3
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pad_cfg_stb, cmd_stb}));

   // R3
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cmd_stb) || pad_cfg_stb) |=> (cmd_stb == '0) && !pad_cfg_stb);

   // R3
   arg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb == '0) |-> (cmd_arg == '0));

   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R7
   quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cmd_stb == '0) && !pad_cfg_stb);

   // R2
   flavour_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_LATCH && st != ST_ISSUE) |-> $stable(flav));

   // R8
   refresh_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> refresh_ctl[14] && refresh_ctl[9:0] == 10'(REF_COUNT));

endmodule

// File: tb/dram_init_seq_tb.sv
`timescale 1ns/1ps
module dram_init_seq_tb;

   localparam int LG    = 20;   // 100 * 200 / 1000
   localparam int SH    = 2;    // 10 * 200 / 1000
   localparam int T0    = 3;    // sample index of the first strobe
   localparam int LANES = 2;
   localparam int TAP_W = 6;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   strap_ddr2 = 1'b0;
   logic [5:0]             cmd_stb;
   logic [12:0]            cmd_arg;
   logic                   pad_cfg_stb;
   logic                   init_done;
   logic [15:0]            refresh_ctl;
   logic [LANES*TAP_W-1:0] dqs_tap;

   always #2.5 clk = ~clk;

   dram_init_seq #(.TIME_DIV(1000)) u_dut (
      .clk(clk), .rst_n(rst_n), .strap_ddr2(strap_ddr2),
      .cmd_stb(cmd_stb), .cmd_arg(cmd_arg), .pad_cfg_stb(pad_cfg_stb),
      .init_done(init_done), .refresh_ctl(refresh_ctl), .dqs_tap(dqs_tap)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Event log, sampled on falling edges
   int         t;
   int         ev_n;
   int         ev_t   [32];
   logic [5:0] ev_s   [32];
   bit         ev_p   [32];
   int         ev_a   [32];
   int         done_t;
   int         junk;

   always @(negedge clk) begin
      if (!rst_n) begin
         t = 0; ev_n = 0; done_t = -1; junk = 0;
      end else begin
         t++;
         if ((|cmd_stb) || pad_cfg_stb) begin
            if (ev_n < 32) begin
               ev_t[ev_n] = t; ev_s[ev_n] = cmd_stb;
               ev_p[ev_n] = pad_cfg_stb; ev_a[ev_n] = int'(cmd_arg);
            end
            ev_n++;
         end
         if (cmd_stb == 6'd0 && cmd_arg != 13'd0) junk++;
         if (init_done && done_t < 0) done_t = t;
      end
   end

   // Expected step tables from R4 and R5
   task automatic exp_step(input bit d2, input int j, output logic [5:0] s,
                           output bit p, output int a, output int g);
      p = 0; a = 0; g = LG;
      if (!d2) begin
         case (j)
            0: s = 6'h08; 1: s = 6'h02;
            2: begin s = 6'h01; a = 'h133; end
            3: s = 6'h08; 4: s = 6'h04; 5: s = 6'h04;
            default: begin s = 6'h01; a = 'h033; end
         endcase
      end else begin
         case (j)
            0: begin s = 6'h10; g = SH; end
            1: begin s = 6'h20; g = SH; end
            2: begin s = 6'h00; p = 1; g = SH; end
            3: s = 6'h08; 4: s = 6'h10; 5: s = 6'h20;
            6: begin s = 6'h02; a = 'h402; end
            7: begin s = 6'h01; a = 'h143; end
            8: s = 6'h08; 9: s = 6'h04; 10: s = 6'h04;
            11: begin s = 6'h01; a = 'h043; end
            12: begin s = 6'h02; a = 'h782; end
            default: begin s = 6'h02; a = 'h402; end
         endcase
      end
   endtask

   task automatic run(input bit d2, input int hold, input bit mid_rst,
                      input int mid_at, input bit toggle);
      int nexp;
      int tt;
      int lim;
      logic [5:0] s; bit p; int a; int g;
      @(posedge clk); #1;
      rst_n = 1'b0; strap_ddr2 = mid_rst ? ~d2 : d2;
      repeat (hold) @(posedge clk);
      #1;
      // R1 reset state
      chk(cmd_stb == 0 && cmd_arg == 0 && !pad_cfg_stb && !init_done &&
          refresh_ctl == 0 && dqs_tap == 0, "R1", "reset outputs",
          {cmd_stb, cmd_arg, pad_cfg_stb, init_done, refresh_ctl}, 0);
      if (mid_rst) begin
         // R9 abort part way and restart with a new strap
         rst_n = 1'b1;
         repeat (mid_at) @(posedge clk);
         #1; rst_n = 1'b0;
         repeat (2) @(posedge clk);
         #1; strap_ddr2 = d2;
      end
      rst_n = 1'b1;
      if (toggle) begin
         repeat (3) @(posedge clk);
         #1; strap_ddr2 = ~d2;   // R2 must be ignored
      end
      repeat (10) @(posedge clk);
      #1;
      // R8 nothing published before done
      chk(refresh_ctl == 0 && dqs_tap == 0, "R8", "pre-done outputs",
          {refresh_ctl, dqs_tap}, 0);
      lim = 0;
      while (!init_done && lim < 2000) begin @(posedge clk); lim++; end
      chk(lim < 2000, "R7", "watchdog done", lim, 0);
      repeat (40) @(posedge clk);
      #1;
      nexp = d2 ? 14 : 7;
      chk(ev_n == nexp, d2 ? "R5" : "R4", "strobe count", ev_n, nexp);
      tt = T0;
      for (int j = 0; j < nexp; j++) begin
         exp_step(d2, j, s, p, a, g);
         if (j < ev_n && j < 32) begin
            chk(ev_s[j] == s && ev_p[j] == p && ev_a[j] == a,
                d2 ? "R5" : "R4", $sformatf("step %0d cmd/pad/arg", j),
                {ev_s[j], 1'(ev_p[j]), 12'(ev_a[j])}, {s, 1'(p), 12'(a)});
            chk(ev_t[j] == tt, "R6", $sformatf("step %0d time", j), ev_t[j], tt);
         end
         tt += g;
      end
      chk(done_t == tt, "R7", "done time", done_t, tt);
      chk(init_done == 1'b1, "R7", "done sticky", init_done, 1);
      chk(refresh_ctl == 16'h4138, "R8", "refresh word", refresh_ctl, 16'h4138);
      chk(dqs_tap == (d2 ? 12'h410 : 12'h820), "R8", "dqs taps", dqs_tap,
          d2 ? 12'h410 : 12'h820);
      chk(junk == 0, "R3", "arg without strobe", junk, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_0421));
      run(1'b0, 3, 1'b0, 0, 1'b0);      // R4 directed DDR1
      run(1'b1, 3, 1'b0, 0, 1'b0);      // R5 directed DDR2
      run(1'b1, 1, 1'b0, 0, 1'b1);      // R2 strap toggled after latch
      run(1'b0, 2, 1'b1, 45, 1'b0);     // R9 reset in the middle of a gap
      for (int r = 0; r < 8; r++) begin
         run(1'($urandom_range(0, 1)), int'($urandom_range(1, 6)),
             1'($urandom_range(0, 1)), int'($urandom_range(1, 120)),
             1'($urandom_range(0, 1)));
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(150000 * 5);
      n_chk++; n_bad++;
      $display("FAIL R7 global watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule